// File: doc/BRIEF.md
# Flash Embedded Operation Engine

This block carries out the internal word-program and erase operations that an upstream command decoder hands it, acting on a small behavioural word array. The busy time of each operation comes from a cycle counter. A program clears bits in one word. An erase sets every bit to 1 across one of three scopes: a sector, a block, or the whole array. An erase can be paused and later continued. While it is paused, a word program may run anywhere outside the paused region.

Each read is served one cycle after the strobe. The block decides whether the read returns array data or a status word. During an operation the host polls two status bits: one reflects the data being written, and the other alternates on every poll. While an erase is paused, reads that fall inside the paused region return a separate status pattern. Reads outside the region return stored data.

Top module: `flash_op_engine`

## Requirements
- R1: A program request (op code 0), accepted while idle, keeps `busy_o` high for exactly PROG_CYC cycles. After that the word at `addr_i` holds its old value ANDed with `wdata_i`. The array resets to all ones.
- R2: An erase request keeps `busy_o` high for exactly ERASE_CYC cycles and then sets every word of the target region to all ones. Op code 1 selects a sector (addresses equal above bit SEC_W), op code 2 selects a block (equal above bit BLK_W), and op code 3 selects the whole array. All other words are unchanged.
- R3: While `busy_o` is high, a read returns a status word in which only bits 7 and 6 can be non-zero. Bit 7 is the inverse of bit 7 of the word being programmed, and it is 0 during an erase or during the suspend latency.
- R4: Bit 6 of the busy status inverts on each successive busy-time read, starting at 0 after reset. Reads made while idle do not advance it.
- R5: When no operation is running, a read returns the array word at `raddr_i` on `rdata_o` one cycle after `rd_i`.
- R6: A suspend request (op code 4) during an erase freezes the erase progress. `busy_o` stays high for SUSP_CYC more cycles, carrying erase status, and then goes low.
- R7: While suspended, a read outside the erase region returns array data. A read inside it returns a word with bit 6 at 1, bit 2 inverting on each such read (starting at 0), and all other bits at 0.
- R8: While suspended, a program outside the erase region runs as in R1 and the engine then returns to the suspended state. A program inside the region is ignored, and `busy_o` stays low.
- R9: A resume request (op code 5) while suspended raises `busy_o` again. The erase then finishes after the cycles it still had left at the moment of the suspend.
- R10: A request that does not fit the present state is ignored. This covers any request while a program is busy, any request other than a suspend while an erase is busy, and a suspend or resume while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Operation request strobe, one cycle |
| op_i | input | 3 | Operation code |
| addr_i | input | ADDR_W | Target word address, or the region address for an erase |
| wdata_i | input | DATA_W | Program data |
| rd_i | input | 1 | Read strobe |
| raddr_i | input | ADDR_W | Read address |
| rdata_o | output | DATA_W | Read result, valid the cycle after `rd_i` |
| busy_o | output | 1 | High while an operation or the suspend latency is running |

## Verification
Programs are tried with data whose bit 7 is both 0 and 1, which separates a correct polling bit from a stuck one. Repeated programs of the same word show whether bits are only cleared or are simply overwritten. Sector, block and whole-array erases are each checked against words just inside and just outside the region, which exposes a wrong boundary bit. A directed suspend sequence polls for a known number of cycles before it suspends, so the length of the resumed erase shows whether progress was frozen or restarted. Randomly mixed programs and erases, each followed by readback against a bench model, cover interactions between operations.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PROG   = 3'd1,
        ST_ERASE  = 3'd2,
        ST_SWAIT  = 3'd3,
        ST_SUSP   = 3'd4,
        ST_PROG_S = 3'd5
    } eng_state_e;

    localparam logic [2:0] OP_PROG = 3'd0;
    localparam logic [2:0] OP_SECT = 3'd1;
    localparam logic [2:0] OP_BLK  = 3'd2;
    localparam logic [2:0] OP_CHIP = 3'd3;
    localparam logic [2:0] OP_SUSP = 3'd4;
    localparam logic [2:0] OP_RES  = 3'd5;

    typedef enum logic [1:0] {
        RG_SECT = 2'd0,
        RG_BLK  = 2'd1,
        RG_CHIP = 2'd2
    } region_e;

endpackage

// File: rtl/flash_region_match.sv
module flash_region_match
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEC_W  = 3,
    parameter int BLK_W  = 5
) (
    input  region_e             kind_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [ADDR_W-1:0]   probe_i,
    output logic                hit_o
);
    localparam logic [ADDR_W-1:0] SEC_MASK = ~ADDR_W'((1 << SEC_W) - 1);
    localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'((1 << BLK_W) - 1);

    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff = base_i ^ probe_i;
        case (kind_i)
            RG_SECT: hit_o = (diff & SEC_MASK) == '0;
            RG_BLK:  hit_o = (diff & BLK_MASK) == '0;
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/flash_status_fmt.sv
module flash_status_fmt #(
    parameter int DATA_W = 16
) (
    input  logic              poll_i,
    input  logic              tog_i,
    input  logic              tog2_i,
    output logic [DATA_W-1:0] busy_word_o,
    output logic [DATA_W-1:0] susp_word_o
);
    always_comb begin
        busy_word_o    = '0;
        busy_word_o[7] = poll_i;
        busy_word_o[6] = tog_i;
        susp_word_o    = '0;
        susp_word_o[6] = 1'b1;
        susp_word_o[2] = tog2_i;
    end
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int SEC_W     = 3,
    parameter int BLK_W     = 5,
    parameter int PROG_CYC  = 10,
    parameter int ERASE_CYC = 40,
    parameter int SUSP_CYC  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o
);
    localparam int WORDS   = 1 << ADDR_W;
    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ?
                             ((PROG_CYC > SUSP_CYC) ? PROG_CYC : SUSP_CYC) :
                             ((ERASE_CYC > SUSP_CYC) ? ERASE_CYC : SUSP_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        eng_state_e                   state;
        logic [CNT_W-1:0]             ecnt;
        logic [CNT_W-1:0]             pcnt;
        logic [CNT_W-1:0]             scnt;
        region_e                      kind;
        logic [ADDR_W-1:0]            eaddr;
        logic [ADDR_W-1:0]            paddr;
        logic [DATA_W-1:0]            pdata;
        logic                         tog;
        logic                         tog2;
        logic [DATA_W-1:0]            rdata;
        logic [WORDS-1:0][DATA_W-1:0] mem;
    } eng_regs_t;

    eng_regs_t q, d;

    logic              rd_hit, pg_hit, poll;
    logic [WORDS-1:0]  wipe;
    logic [DATA_W-1:0] busy_word, susp_word;

    flash_region_match #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .BLK_W(BLK_W)) u_rd_match (
        .kind_i(q.kind), .base_i(q.eaddr), .probe_i(raddr_i), .hit_o(rd_hit)
    );

    flash_region_match #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .BLK_W(BLK_W)) u_pg_match (
        .kind_i(q.kind), .base_i(q.eaddr), .probe_i(addr_i), .hit_o(pg_hit)
    );

    for (genvar w = 0; w < WORDS; w++) begin : g_wipe
        flash_region_match #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .BLK_W(BLK_W)) u_wipe (
            .kind_i(q.kind), .base_i(q.eaddr), .probe_i(ADDR_W'(w)), .hit_o(wipe[w])
        );
    end

    assign poll = (q.state == ST_PROG || q.state == ST_PROG_S) ? ~q.pdata[7] : 1'b0;

    flash_status_fmt #(.DATA_W(DATA_W)) u_status (
        .poll_i(poll), .tog_i(q.tog), .tog2_i(q.tog2),
        .busy_word_o(busy_word), .susp_word_o(susp_word)
    );

    always_comb begin
        d = q;

        // read path
        if (rd_i) begin
            case (q.state)
                ST_PROG, ST_ERASE, ST_SWAIT, ST_PROG_S: begin
                    d.rdata = busy_word;
                    d.tog   = ~q.tog;
                end
                ST_SUSP: begin
                    if (rd_hit) begin
                        d.rdata = susp_word;
                        d.tog2  = ~q.tog2;
                    end else begin
                        d.rdata = q.mem[raddr_i];
                    end
                end
                default: d.rdata = q.mem[raddr_i];
            endcase
        end

        // operation sequencing
        case (q.state)
            ST_IDLE: begin
                if (req_i) begin
                    if (op_i == OP_PROG) begin
                        d.state = ST_PROG;
                        d.pcnt  = CNT_W'(PROG_CYC - 1);
                        d.paddr = addr_i;
                        d.pdata = wdata_i;
                    end else if (op_i == OP_SECT || op_i == OP_BLK || op_i == OP_CHIP) begin
                        d.state = ST_ERASE;
                        d.ecnt  = CNT_W'(ERASE_CYC - 1);
                        d.eaddr = addr_i;
                        d.kind  = (op_i == OP_SECT) ? RG_SECT :
                                  (op_i == OP_BLK)  ? RG_BLK  : RG_CHIP;
                    end
                end
            end
            ST_PROG, ST_PROG_S: begin
                if (q.pcnt == '0) begin
                    d.mem[q.paddr] = q.mem[q.paddr] & q.pdata;
                    d.state        = (q.state == ST_PROG) ? ST_IDLE : ST_SUSP;
                end else begin
                    d.pcnt = q.pcnt - 1'b1;
                end
            end
            ST_ERASE: begin
                if (req_i && op_i == OP_SUSP) begin
                    d.state = ST_SWAIT;
                    d.scnt  = CNT_W'(SUSP_CYC - 1);
                end else if (q.ecnt == '0) begin
                    for (int w = 0; w < WORDS; w++) begin
                        if (wipe[w]) d.mem[w] = '1;
                    end
                    d.state = ST_IDLE;
                end else begin
                    d.ecnt = q.ecnt - 1'b1;
                end
            end
            ST_SWAIT: begin
                if (q.scnt == '0) d.state = ST_SUSP;
                else              d.scnt  = q.scnt - 1'b1;
            end
            ST_SUSP: begin
                if (req_i) begin
                    if (op_i == OP_RES) begin
                        d.state = ST_ERASE;
                    end else if (op_i == OP_PROG && !pg_hit) begin
                        d.state = ST_PROG_S;
                        d.pcnt  = CNT_W'(PROG_CYC - 1);
                        d.paddr = addr_i;
                        d.pdata = wdata_i;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q     <= '0;
            q.mem <= '1;
        end else begin
            q <= d;
        end
    end

    assign rdata_o = q.rdata;
    assign busy_o  = (q.state == ST_PROG) || (q.state == ST_ERASE) ||
                     (q.state == ST_SWAIT) || (q.state == ST_PROG_S);
endmodule

// File: rtl/flash_op_engine_chk.sv
module flash_op_engine_chk #(
    parameter int DATA_W    = 16,
    parameter int ERASE_CYC = 40,
    parameter int SUSP_CYC  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_i,
    input logic              rd_i,
    input logic              busy_o,
    input logic [DATA_W-1:0] rdata_o
);
    localparam int RUN_MAX = ERASE_CYC + SUSP_CYC;

    logic        st_q, seen_q, last_q;
    logic [31:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q   <= 1'b0;
            seen_q <= 1'b0;
            last_q <= 1'b0;
            run_q  <= '0;
        end else begin
            st_q <= rd_i && busy_o;
            if (st_q) begin
                p_toggle_alt_r4: assert (!seen_q || rdata_o[6] != last_q);
                seen_q <= 1'b1;
                last_q <= rdata_o[6];
            end
            run_q <= busy_o ? run_q + 1 : '0;
        end
    end

    // R3: busy-time reads carry only the two status bits
    p_status_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && busy_o) |=> (rdata_o[DATA_W-1:8] == '0 && rdata_o[5:0] == '0));

    // R10: busy only starts on an accepted request
    p_busy_from_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(req_i));

    // R6: no busy stretch outlasts an erase plus its suspend latency
    p_busy_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q <= 32'(RUN_MAX));
endmodule

bind flash_op_engine flash_op_engine_chk #(
    .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC), .SUSP_CYC(SUSP_CYC)
) i_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .rd_i(rd_i),
    .busy_o(busy_o), .rdata_o(rdata_o)
);

// File: tb/test_flash_op_engine.sv
module test_flash_op_engine;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int SW = 3;
    localparam int BW = 5;
    localparam int PC = 10;
    localparam int EC = 40;
    localparam int SC = 4;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [2:0]    op = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          rd = 1'b0;
    logic [AW-1:0] raddr = '0;
    logic [DW-1:0] rdata;
    logic          busy;

    logic [DW-1:0] mdl [NW];
    bit            e_tog = 1'b0;
    bit            e_tog2 = 1'b0;
    int            n_tests = 0;
    int            n_fail = 0;

    always #4 clk = ~clk;

    flash_op_engine #(
        .ADDR_W(AW), .DATA_W(DW), .SEC_W(SW), .BLK_W(BW),
        .PROG_CYC(PC), .ERASE_CYC(EC), .SUSP_CYC(SC)
    ) i_flash_op_engine (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
        .wdata_i(wdata), .rd_i(rd), .raddr_i(raddr), .rdata_o(rdata), .busy_o(busy)
    );

    function automatic logic [DW-1:0] busy_word(input bit poll, input bit tg);
        logic [DW-1:0] w = '0;
        w[7] = poll;
        w[6] = tg;
        return w;
    endfunction

    function automatic logic [DW-1:0] susp_word(input bit tg2);
        logic [DW-1:0] w = '0;
        w[6] = 1'b1;
        w[2] = tg2;
        return w;
    endfunction

    function automatic bit in_region(input int kind, input int base, input int a);
        if (kind == 1) return (base >> SW) == (a >> SW);
        if (kind == 2) return (base >> BW) == (a >> BW);
        return 1'b1;
    endfunction

    task automatic check(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic do_read(input int a, output logic [DW-1:0] v);
        rd = 1'b1;
        raddr = AW'(a);
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic issue(input logic [2:0] o, input int a, input logic [DW-1:0] dt);
        req = 1'b1;
        op = o;
        addr = AW'(a);
        wdata = dt;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic stat_read(input bit poll, input string rq);
        logic [DW-1:0] v;
        do_read($urandom % NW, v);
        check(rq, v, busy_word(poll, e_tog));
        e_tog = ~e_tog;
    endtask

    task automatic run_busy(input bit poll, output int cyc);
        cyc = 0;
        while (busy && cyc < 1000) begin
            stat_read(poll, "R3/R4 busy status");
            cyc++;
        end
    endtask

    task automatic prog(input int a, input logic [DW-1:0] dt);
        int cyc;
        issue(3'd0, a, dt);
        run_busy(~dt[7], cyc);
        check("R1 program busy length", DW'(cyc), DW'(PC));
        mdl[a] = mdl[a] & dt;
    endtask

    task automatic erase(input int kind, input int a);
        int cyc;
        issue(3'(kind), a, '0);
        run_busy(1'b0, cyc);
        check("R2 erase busy length", DW'(cyc), DW'(EC));
        for (int w = 0; w < NW; w++) if (in_region(kind, a, w)) mdl[w] = '1;
    endtask

    task automatic verify(input int a, input string rq);
        logic [DW-1:0] v;
        do_read(a, v);
        check(rq, v, mdl[a]);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int cyc;
        void'($urandom(32'd1234));
        for (int w = 0; w < NW; w++) mdl[w] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R10 idle busy after reset", DW'(busy), '0);
        verify(0, "R5 erased array after reset");

        // programming, AND behaviour, both polling polarities (R1, R3)
        prog(5, 16'h1234);
        verify(5, "R1 first program");
        prog(5, 16'hFF8F);
        verify(5, "R1 program only clears bits");

        // R10: second request while programming ignored
        issue(3'd0, 9, 16'h0000);
        stat_read(1'b1, "R3 poll during program");
        stat_read(1'b1, "R4 toggle during program");
        issue(3'd0, 10, 16'h0000);
        run_busy(1'b1, cyc);
        check("R10 busy length unchanged by extra request", DW'(cyc + 3), DW'(PC));
        mdl[9] = '0;
        verify(10, "R10 ignored program left word intact");
        verify(9, "R1 program data");

        // R5: idle reads do not advance toggle; R4 checked through next status read
        verify(9, "R5 idle read");

        // sector erase (R2)
        prog(8, 16'h0000);
        erase(1, 5);
        verify(5, "R2 sector erased");
        verify(0, "R2 sector low edge");
        verify(7, "R2 sector high edge");
        verify(8, "R2 neighbour sector untouched");
        verify(9, "R2 neighbour sector untouched");

        // block erase (R2)
        prog(40, 16'h0000);
        prog(70, 16'h0000);
        prog(31, 16'h0000);
        erase(2, 33);
        verify(40, "R2 block erased");
        verify(70, "R2 next block untouched");
        verify(31, "R2 previous block untouched");

        // suspend / resume (R6..R9)
        prog(100, 16'h0000);
        prog(120, 16'h0000);
        issue(3'd1, 98, '0);
        for (int k = 0; k < 5; k++) stat_read(1'b0, "R3 erase poll zero");
        issue(3'd4, 0, '0);
        run_busy(1'b0, cyc);
        check("R6 suspend latency", DW'(cyc), DW'(SC));
        check("R6 busy low when suspended", DW'(busy), '0);
        do_read(100, v);
        check("R7 suspended region status", v, susp_word(e_tog2));
        e_tog2 = ~e_tog2;
        do_read(97, v);
        check("R7 suspended region toggle", v, susp_word(e_tog2));
        e_tog2 = ~e_tog2;
        verify(120, "R7 read outside region");
        issue(3'd0, 101, 16'h0000);
        check("R8 program inside region ignored", DW'(busy), '0);
        do_read(101, v);
        check("R8 still suspended after ignored program", v, susp_word(e_tog2));
        e_tog2 = ~e_tog2;
        issue(3'd3, 0, '0);
        check("R10 erase request while suspended ignored", DW'(busy), '0);
        prog(130, 16'h5A5A);
        check("R8 back to suspended after program", DW'(busy), '0);
        verify(130, "R8 program outside region");
        issue(3'd5, 0, '0);
        run_busy(1'b0, cyc);
        check("R9 resumed erase remaining length", DW'(cyc), DW'(EC - 5));
        for (int w = 96; w < 104; w++) mdl[w] = '1;
        verify(100, "R9 erase completed after resume");
        verify(101, "R9 erase completed after resume");
        verify(120, "R9 outside word intact");

        // R10: suspend and resume while idle ignored
        issue(3'd5, 0, '0);
        check("R10 resume while idle ignored", DW'(busy), '0);
        issue(3'd4, 0, '0);
        check("R10 suspend while idle ignored", DW'(busy), '0);

        // chip erase (R2)
        prog(200, 16'h0F0F);
        erase(3, 0);
        verify(200, "R2 chip erase");
        verify(130, "R2 chip erase");

        // random mix
        for (int it = 0; it < 40; it++) begin
            int r = $urandom % 5;
            int a = $urandom % NW;
            if (r < 3) prog(a, DW'($urandom));
            else if (r == 3) erase(1, a);
            else erase(2, a);
            for (int k = 0; k < 3; k++) verify($urandom % NW, "R1/R2/R5 random readback");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule